// File: doc/BRIEF.md
# Two-Level Latched Interrupt Aggregator

This block gathers seventeen level-sensitive interrupt lines and eight bus event flags into a first-level status word. Each source that is seen high sets its own sticky bit, and software clears bits by writing ones to them. A first-level mask and a global enable bit in a control word reduce that status to a single request. The request appears live, without any storage, at bit 11 of a read-only second-level input word.

The second level latches the input word, through its own mask, into a second-level status word. That status is also write-one-to-clear. The single interrupt output is high whenever the second-level status is nonzero, so the output stays asserted after its cause has gone until software clears the second-level bit. A polarity word is stored and can be read back, but it has no effect on the logic.

Software reaches both levels through one 32-bit register port. Address bit 8 selects the level, and the low eight bits select the word within that level. Writes take effect on the clock edge. Reads are combinational from the current register contents.

Top module: `irq_aggregator`

## Requirements
- R1: During reset and after it, every stored word is zero and `irqOut` is low.
- R2: Interrupt line n (0 to 16) sampled high at a clock edge sets first-level status bit 31−n at that edge. The bit stays set after the line returns low.
- R3: Event input k (0 to 7) sampled high at a clock edge sets first-level status bit k at that edge, and the bit is sticky. Status bits 14 to 8 always read as zero.
- R4: A write to first-level status (address 0x038) clears each bit written as one and leaves the other bits unchanged. When a source is high in the same cycle, its set wins over the clear.
- R5: The request is high exactly when control bit 31 (address 0x030) is one and (first-level status AND first-level mask, address 0x034) is nonzero. The second-level input word (address 0x15C) reads the request at bit 11 in the same cycle and reads zero in every other bit.
- R6: At each clock edge, second-level status (address 0x150) ORs in (input word AND second-level mask, address 0x154). A set bit clears only by a write of one to 0x150, and it is set again at that same edge if its input and mask bit are still high.
- R7: `irqOut` is high exactly while second-level status is nonzero. Removing the request, the enable or either mask does not lower it.
- R8: The polarity word (address 0x158) reads back the last value written to it and has no effect on any status or on `irqOut`.
- R9: A read of any other address, including unaligned ones, returns 0xFFFFFFFF. Writes to such addresses and to 0x15C change nothing.
- R10: The control word and both mask words read back the full 32-bit value last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqLines | input | 17 | Level interrupt lines; line n maps to status bit 31−n |
| busEvents | input | 8 | Bus error and request events; event k maps to status bit k |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 9 | Register address; bit 8 selects the level |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational from the address |
| irqOut | output | 1 | Aggregated interrupt output |

## Verification
A source sampled at an edge appears in the first-level status, and therefore in the request and the input word, straight after that edge. The second-level status and `irqOut` follow one edge later. A register write is visible on read-back straight after its edge, and a mask-2 write reaches `irqOut` one edge after that. The bench drives every input on the falling edge and keeps a behavioural model that steps on each rising edge. It compares `irqOut` and the read data for the current address 1 ns after each rising edge. The directed checks also sample `irqOut` in the cycle before the second-level latch, to confirm that the extra cycle is really there.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 9;

  // word offsets inside each level window (address bit 8 picks the level)
  localparam logic [7:0] OFS_CTRL  = 8'h30;
  localparam logic [7:0] OFS_MASK1 = 8'h34;
  localparam logic [7:0] OFS_STAT1 = 8'h38;
  localparam logic [7:0] OFS_STAT2 = 8'h50;
  localparam logic [7:0] OFS_MASK2 = 8'h54;
  localparam logic [7:0] OFS_POL   = 8'h58;
  localparam logic [7:0] OFS_IN2   = 8'h5C;

  typedef struct packed {
    logic wrCtrl;
    logic wrMask;
    logic clrStat;
  } l1Strobe_t;

  typedef struct packed {
    logic wrMask;
    logic clrStat;
    logic wrPol;
  } l2Strobe_t;

  typedef struct packed {
    l1Strobe_t lvl1;
    l2Strobe_t lvl2;
  } strobe_t;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_MASK1,
    SEL_STAT1,
    SEL_STAT2,
    SEL_MASK2,
    SEL_POL,
    SEL_IN2
  } rdSel_t;

endpackage

// File: rtl/irqagg_ctrl.sv
module irqagg_ctrl
  import irqagg_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           stb,
  output rdSel_t            rdSel
);

  logic       upperWin;
  logic [7:0] ofs;

  assign upperWin = addr[ADDR_W-1];
  assign ofs      = addr[7:0];

  always_comb begin
    rdSel = SEL_NONE;
    if (!upperWin) begin
      unique case (ofs)
        OFS_CTRL:  rdSel = SEL_CTRL;
        OFS_MASK1: rdSel = SEL_MASK1;
        OFS_STAT1: rdSel = SEL_STAT1;
        default:   rdSel = SEL_NONE;
      endcase
    end else begin
      unique case (ofs)
        OFS_STAT2: rdSel = SEL_STAT2;
        OFS_MASK2: rdSel = SEL_MASK2;
        OFS_POL:   rdSel = SEL_POL;
        OFS_IN2:   rdSel = SEL_IN2;
        default:   rdSel = SEL_NONE;
      endcase
    end
  end

  always_comb begin
    stb = '0;
    if (wrEn) begin
      stb.lvl1.wrCtrl  = (rdSel == SEL_CTRL);
      stb.lvl1.wrMask  = (rdSel == SEL_MASK1);
      stb.lvl1.clrStat = (rdSel == SEL_STAT1);
      stb.lvl2.clrStat = (rdSel == SEL_STAT2);
      stb.lvl2.wrMask  = (rdSel == SEL_MASK2);
      stb.lvl2.wrPol   = (rdSel == SEL_POL);
    end
  end

endmodule

// File: rtl/irqagg_lvl1.sv
module irqagg_lvl1
  import irqagg_pkg::*;
#(
  parameter int NUM_LINES = 17,
  parameter int NUM_EVT   = 8,
  parameter int EN_BIT    = 31
) (
  input  logic               clk,
  input  logic               rstN,
  input  l1Strobe_t          stb,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_LINES-1:0] lines,
  input  logic [NUM_EVT-1:0] events,
  output logic [DATA_W-1:0]  ctrlQ,
  output logic [DATA_W-1:0]  maskQ,
  output logic [DATA_W-1:0]  statQ,
  output logic               req
);

  logic [DATA_W-1:0] setVec;
  logic [DATA_W-1:0] clrVec;

  // lines fill from the top bit downward, events from bit 0 upward
  always_comb begin
    setVec = '0;
    for (int n = 0; n < NUM_LINES; n++) setVec[DATA_W-1-n] = lines[n];
    for (int k = 0; k < NUM_EVT; k++) setVec[k] = events[k];
  end

  assign clrVec = stb.clrStat ? wrData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
      maskQ <= '0;
      statQ <= '0;
    end else begin
      if (stb.wrCtrl) ctrlQ <= wrData;
      if (stb.wrMask) maskQ <= wrData;
      statQ <= (statQ & ~clrVec) | setVec;
    end
  end

  assign req = ctrlQ[EN_BIT] && ((statQ & maskQ) != '0);

endmodule

// File: rtl/irqagg_lvl2.sv
module irqagg_lvl2
  import irqagg_pkg::*;
#(
  parameter int REQ_BIT = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  l2Strobe_t         stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              req,
  output logic [DATA_W-1:0] inQ,
  output logic [DATA_W-1:0] maskQ,
  output logic [DATA_W-1:0] statQ,
  output logic [DATA_W-1:0] polQ,
  output logic              irqOut
);

  logic [DATA_W-1:0] clrVec;

  always_comb begin
    inQ          = '0;
    inQ[REQ_BIT] = req;
  end

  assign clrVec = stb.clrStat ? wrData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '0;
      statQ <= '0;
      polQ  <= '0;
    end else begin
      if (stb.wrMask) maskQ <= wrData;
      if (stb.wrPol)  polQ  <= wrData;
      statQ <= (statQ & ~clrVec) | (inQ & maskQ);
    end
  end

  assign irqOut = (statQ != '0);

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irqagg_pkg::*;
#(
  parameter int NUM_LINES = 17,
  parameter int NUM_EVT   = 8,
  parameter int REQ_BIT   = 11
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqLines,
  input  logic [NUM_EVT-1:0]   busEvents,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData,
  output logic                 irqOut
);

  strobe_t           stb;
  rdSel_t            rdSel;
  logic              l1Req;
  logic [DATA_W-1:0] ctrlQ, mask1Q, stat1Q;
  logic [DATA_W-1:0] in2Q, mask2Q, stat2Q, polQ;

  irqagg_ctrl u_ctrl (
    .wrEn  (regWrEn),
    .addr  (regAddr),
    .stb   (stb),
    .rdSel (rdSel)
  );

  irqagg_lvl1 #(
    .NUM_LINES (NUM_LINES),
    .NUM_EVT   (NUM_EVT)
  ) u_lvl1 (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb.lvl1),
    .wrData (regWrData),
    .lines  (irqLines),
    .events (busEvents),
    .ctrlQ  (ctrlQ),
    .maskQ  (mask1Q),
    .statQ  (stat1Q),
    .req    (l1Req)
  );

  irqagg_lvl2 #(
    .REQ_BIT (REQ_BIT)
  ) u_lvl2 (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb.lvl2),
    .wrData (regWrData),
    .req    (l1Req),
    .inQ    (in2Q),
    .maskQ  (mask2Q),
    .statQ  (stat2Q),
    .polQ   (polQ),
    .irqOut (irqOut)
  );

  always_comb begin
    unique case (rdSel)
      SEL_CTRL:  regRdData = ctrlQ;
      SEL_MASK1: regRdData = mask1Q;
      SEL_STAT1: regRdData = stat1Q;
      SEL_STAT2: regRdData = stat2Q;
      SEL_MASK2: regRdData = mask2Q;
      SEL_POL:   regRdData = polQ;
      SEL_IN2:   regRdData = in2Q;
      default:   regRdData = '1;
    endcase
  end

endmodule

// File: rtl/irqagg_checker.sv
module irqagg_checker #(
  parameter int REQ_BIT = 11
) (
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic [8:0]  regAddr,
  input logic [31:0] regWrData,
  input logic [31:0] regRdData,
  input logic        irqOut,
  input logic        l1Req
);

  logic mapped;
  always_comb begin
    case (regAddr)
      9'h030, 9'h034, 9'h038, 9'h150, 9'h154, 9'h158, 9'h15C: mapped = 1'b1;
      default: mapped = 1'b0;
    endcase
  end

  // R1: output held low while reset is applied
  always @(posedge clk) begin
    if (!rstN) begin
      p_reset_low_r1: assert (!irqOut) else $error("irqOut high in reset");
    end
  end

  // R5: clearing the enable bit drops the request on the next cycle
  p_enable_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 9'h030 && !regWrData[31]) |=> !l1Req);

  // R5: the input word shows the request live at its bit
  p_input_live_r5: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 9'h15C) |-> (regRdData == (32'(l1Req) << REQ_BIT)));

  // R6: the output can only rise after a request was present
  p_rise_needs_req_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(l1Req));

  // R7: the output stays up unless the second-level bit is cleared
  p_out_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !(regWrEn && regAddr == 9'h150 && regWrData[REQ_BIT])) |=> irqOut);

  // R9: unmapped addresses read as all ones
  p_unmapped_ones_r9: assert property (@(posedge clk) disable iff (!rstN)
    !mapped |-> (regRdData == 32'hFFFF_FFFF));

endmodule

bind irq_aggregator irqagg_checker #(.REQ_BIT(REQ_BIT)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .regRdData (regRdData),
  .irqOut    (irqOut),
  .l1Req     (l1Req)
);

// File: tb/tb_irq_aggregator.sv
`timescale 1ns/1ps
module tb_irq_aggregator;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [16:0] irqLines = '0;
  logic [7:0]  busEvents = '0;
  logic        regWrEn = 1'b0;
  logic [8:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irqOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  irq_aggregator dut (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .busEvents(busEvents),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut(irqOut)
  );

  // behavioural reference model
  logic [31:0] mCtrl = 0, mMask1 = 0, mStat1 = 0, mMask2 = 0, mStat2 = 0, mPol = 0;

  function automatic logic mReq();
    return mCtrl[31] && ((mStat1 & mMask1) != 0);
  endfunction

  function automatic logic [31:0] mRead(input logic [8:0] a);
    case (a)
      9'h030: return mCtrl;
      9'h034: return mMask1;
      9'h038: return mStat1;
      9'h150: return mStat2;
      9'h154: return mMask2;
      9'h158: return mPol;
      9'h15C: return mReq() ? 32'h800 : 32'h0;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic string tagOf(input logic [8:0] a);
    case (a)
      9'h030, 9'h034, 9'h154: return "R10";
      9'h038: return "R2";
      9'h150: return "R6";
      9'h158: return "R8";
      9'h15C: return "R5";
      default: return "R9";
    endcase
  endfunction

  always @(posedge clk) begin
    logic [31:0] setV, in2, c1, c2;
    if (!rstN) begin
      mCtrl = 0; mMask1 = 0; mStat1 = 0; mMask2 = 0; mStat2 = 0; mPol = 0;
    end else begin
      setV = 0;
      for (int n = 0; n < 17; n++) setV[31-n] = irqLines[n];
      for (int k = 0; k < 8; k++) setV[k] = busEvents[k];
      in2 = mReq() ? 32'h800 : 32'h0;
      c1 = (regWrEn && regAddr == 9'h038) ? regWrData : 32'h0;
      c2 = (regWrEn && regAddr == 9'h150) ? regWrData : 32'h0;
      mStat2 = (mStat2 & ~c2) | (in2 & mMask2);
      mStat1 = (mStat1 & ~c1) | setV;
      if (regWrEn) begin
        case (regAddr)
          9'h030: mCtrl  = regWrData;
          9'h034: mMask1 = regWrData;
          9'h154: mMask2 = regWrData;
          9'h158: mPol   = regWrData;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  // continuous comparison against the model, away from the edge
  always @(posedge clk) begin
    #1;
    if (!done) begin
      chk("R7", {31'b0, irqOut}, {31'b0, (mStat2 != 0)});
      chk(tagOf(regAddr), regRdData, mRead(regAddr));
    end
  end

  task automatic wrReg(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic chkRd(input string tag, input logic [8:0] a, input logic [31:0] exp);
    regAddr = a;
    #1;
    chk(tag, regRdData, exp);
  endtask

  task automatic chkIrq(input string tag, input logic exp);
    chk(tag, {31'b0, irqOut}, {31'b0, exp});
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chkIrq("R1", 1'b0);
    chkRd("R1", 9'h038, 32'h0);
    chkRd("R1", 9'h150, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chkRd("R1", 9'h030, 32'h0);
    chkRd("R1", 9'h034, 32'h0);
    chkRd("R1", 9'h154, 32'h0);
    chkRd("R1", 9'h158, 32'h0);
    chkRd("R1", 9'h15C, 32'h0);
    chkIrq("R1", 1'b0);

    // R10: read-back of control and masks
    wrReg(9'h030, 32'h8000_1234);
    chkRd("R10", 9'h030, 32'h8000_1234);
    wrReg(9'h154, 32'h0000_0400);
    chkRd("R10", 9'h154, 32'h0000_0400);
    wrReg(9'h154, 32'h0);

    // R2: line 3 pulse sets bit 28 and stays
    @(negedge clk); irqLines[3] = 1'b1;
    @(negedge clk); irqLines[3] = 1'b0;
    @(negedge clk);
    chkRd("R2", 9'h038, 32'h1000_0000);
    chkIrq("R2", 1'b0);

    // R3: event 2 pulse sets bit 2
    busEvents[2] = 1'b1;
    @(negedge clk); busEvents[2] = 1'b0;
    @(negedge clk);
    chkRd("R3", 9'h038, 32'h1000_0004);

    // R5: request gated by mask and enable
    chkRd("R5", 9'h15C, 32'h0);
    wrReg(9'h034, 32'h1000_0000);
    chkRd("R5", 9'h15C, 32'h0000_0800);
    wrReg(9'h030, 32'h0000_1234);
    chkRd("R5", 9'h15C, 32'h0);
    wrReg(9'h030, 32'h8000_0000);
    chkRd("R5", 9'h15C, 32'h0000_0800);

    // R6: second-level latch one edge after the mask write
    chkRd("R6", 9'h150, 32'h0);
    wrReg(9'h154, 32'h0000_0800);
    chkIrq("R6", 1'b0);
    @(negedge clk);
    chkRd("R6", 9'h150, 32'h0000_0800);
    chkIrq("R6", 1'b1);
    wrReg(9'h150, 32'h0000_0800);
    chkRd("R6", 9'h150, 32'h0000_0800);

    // R7: output held after mask and request go away
    wrReg(9'h154, 32'h0);
    chkIrq("R7", 1'b1);
    wrReg(9'h034, 32'h0);
    chkRd("R7", 9'h15C, 32'h0);
    chkIrq("R7", 1'b1);
    wrReg(9'h150, 32'h0000_0800);
    chkRd("R6", 9'h150, 32'h0);
    chkIrq("R7", 1'b0);

    // R4: write-one-to-clear, set wins when source high
    wrReg(9'h038, 32'h0000_0004);
    chkRd("R4", 9'h038, 32'h1000_0000);
    irqLines[0] = 1'b1;
    wrReg(9'h038, 32'h8000_0000);
    chkRd("R4", 9'h038, 32'h9000_0000);
    irqLines[0] = 1'b0;
    wrReg(9'h038, 32'h9000_0000);
    chkRd("R4", 9'h038, 32'h0);

    // R2 / R3: extreme line and event bits
    irqLines[16] = 1'b1; busEvents[7] = 1'b1;
    @(negedge clk); irqLines[16] = 1'b0; busEvents[7] = 1'b0;
    @(negedge clk);
    chkRd("R3", 9'h038, 32'h0000_8080);

    // R9: unmapped reads and ignored writes
    chkRd("R9", 9'h03C, 32'hFFFF_FFFF);
    chkRd("R9", 9'h100, 32'hFFFF_FFFF);
    chkRd("R9", 9'h05C, 32'hFFFF_FFFF);
    chkRd("R9", 9'h131, 32'hFFFF_FFFF);
    wrReg(9'h03C, 32'h1);
    wrReg(9'h15C, 32'hFFFF_FFFF);
    wrReg(9'h130, 32'h0);
    wrReg(9'h031, 32'h0);
    chkRd("R9", 9'h030, 32'h8000_0000);
    chkRd("R9", 9'h15C, 32'h0);
    chkRd("R9", 9'h038, 32'h0000_8080);
    chkIrq("R9", 1'b0);

    // R8: polarity stored, no effect on the chain
    wrReg(9'h158, 32'hA5A5_5A5A);
    chkRd("R8", 9'h158, 32'hA5A5_5A5A);
    chkIrq("R8", 1'b0);
    wrReg(9'h034, 32'h0000_0080);
    wrReg(9'h154, 32'h0000_0800);
    @(negedge clk);
    chkIrq("R8", 1'b1);
    chkRd("R8", 9'h150, 32'h0000_0800);

    repeat (4) @(negedge clk);
    finishRun();
  end

endmodule